// File: doc/BRIEF.md
# Bridge Address Window Forward Decoder

This block sits on the upstream side of a bus-to-bus bridge. It decides, for every address phase, whether the transaction should be claimed and passed to the downstream bus. The decision comes from three programmable windows: an I/O window with 4 KB granularity and full 32-bit reach, a memory window and a prefetchable memory window, each with 1 MB granularity. Two further rules refine the decision. An ISA alias filter keeps the aliased upper 768 bytes of every 1 KB block in the low 64 KB of I/O space local. A set of fixed legacy serial and parallel port ranges can be forwarded regardless of the window settings.

The configuration fields arrive as plain inputs from the bridge's register file. The command selects which windows apply. The registered decision is valid one clock after the address phase. Data movement, posting and the reverse direction belong to other blocks.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: While rst_ni is low, and on the first clock after it, fwd_valid_o and fwd_o are 0.
- R2: An address phase (addr_valid_i high at a rising edge) yields fwd_valid_o high, with the decision on fwd_o, after exactly that edge. With no address phase, fwd_valid_o and fwd_o are 0 after the edge.
- R3: I/O commands 4'b0010 (read) and 4'b0011 (write) are forwarded when {io_base_hi_i, io_base_i, 12'h000} <= addr_i <= {io_limit_hi_i, io_limit_i, 12'hFFF}.
- R4: Memory commands 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111 are forwarded when {mem_base_i, 20'h00000} <= addr_i <= {mem_limit_i, 20'hFFFFF}.
- R5: Memory commands are also forwarded when {pf_base_i, 20'h00000} <= addr_i <= {pf_limit_i, 20'hFFFFF}. A hit in either memory window is enough.
- R6: A window whose limit field is below its base field forwards nothing.
- R7: With isa_en_i set, an I/O address with addr_i[31:16] == 0 and addr_i[9:8] != 0 is not forwarded by the I/O window. I/O addresses with addr_i[9:8] == 0, or at or above 64 KB, are unaffected.
- R8: For I/O commands, port_en_i[0] forwards 3F8h–3FFh, [1] forwards 2F8h–2FFh, [2] forwards 378h–37Fh and [3] forwards 278h–27Fh. These ranges are forwarded whatever the window and ISA settings; addr_i[31:16] must be 0.
- R9: I/O addresses under memory commands, memory addresses under I/O commands, and every other command code (for example 4'b0000 or 4'b1010) are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Upstream bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Address phase strobe |
| addr_i | input | 32 | Transaction address |
| cmd_i | input | 4 | Bus command code |
| io_base_i | input | 4 | I/O base, address bits 15:12 |
| io_limit_i | input | 4 | I/O limit, address bits 15:12 |
| io_base_hi_i | input | 16 | I/O base, address bits 31:16 |
| io_limit_hi_i | input | 16 | I/O limit, address bits 31:16 |
| mem_base_i | input | 12 | Memory base, address bits 31:20 |
| mem_limit_i | input | 12 | Memory limit, address bits 31:20 |
| pf_base_i | input | 12 | Prefetchable base, address bits 31:20 |
| pf_limit_i | input | 12 | Prefetchable limit, address bits 31:20 |
| isa_en_i | input | 1 | ISA alias filter enable |
| port_en_i | input | 4 | Legacy port range enables |
| fwd_valid_o | output | 1 | Decision valid |
| fwd_o | output | 1 | Forward to downstream bus |

## Verification
The bench targets the first and last byte of each window and the byte on each side of them. A design that treats the limit low bits as zero, or uses a strict compare, loses the top 4 KB or 1 MB of a window or gains one unit beyond it. Inverted windows, and an I/O window placed above 64 KB, expose code that only compares 16 bits or forwards on the wrong test. ISA tests cover the 100h–3FFh offsets of a 1 KB block and the same offsets above 64 KB; a filter missing the 64 KB qualifier blocks the high window. Port tests use legacy addresses inside filtered space, with the window disabled and memory commands applied. These catch a port decode lost behind the filter, a wrong range table, or commands that are not gated.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int ADDR_W = 32;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef enum logic [1:0] {SPACE_NONE, SPACE_IO, SPACE_MEM} space_e;

  function automatic space_e cmd_space(input logic [3:0] cmd);
    case (cmd)
      CMD_IO_RD, CMD_IO_WR: return SPACE_IO;
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
      CMD_MEM_RDL, CMD_MEM_WRI: return SPACE_MEM;
      default: return SPACE_NONE;
    endcase
  endfunction

  // Legacy port range starts; every range is 8 bytes long
  function automatic logic [15:0] legacy_port_base(input int idx);
    case (idx)
      0: return 16'h03F8;
      1: return 16'h02F8;
      2: return 16'h0378;
      default: return 16'h0278;
    endcase
  endfunction
endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int ADDR_W  = 32,
  parameter int NIB_W   = 4,
  parameter int GRAN_W  = 12,
  parameter int ISA_W   = 16,
  parameter int BLK_W   = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NIB_W-1:0]         base_i,
  input  logic [NIB_W-1:0]         limit_i,
  input  logic [ADDR_W-GRAN_W-NIB_W-1:0] base_hi_i,
  input  logic [ADDR_W-GRAN_W-NIB_W-1:0] limit_hi_i,
  input  logic                     isa_en_i,
  output logic                     hit_o
);
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic in_range, low_space, isa_alias;

  assign lo_addr   = {base_hi_i,  base_i,  {GRAN_W{1'b0}}};
  assign hi_addr   = {limit_hi_i, limit_i, {GRAN_W{1'b1}}};
  assign in_range  = (addr_i >= lo_addr) && (addr_i <= hi_addr);
  assign low_space = (addr_i[ADDR_W-1:ISA_W] == '0);
  // only the first quarter of each 1 KB block survives the filter
  assign isa_alias = isa_en_i && low_space && (addr_i[BLK_W-1:BLK_W-2] != 2'b00);
  assign hit_o     = in_range && !isa_alias;

  assert_isa_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isa_en_i && addr_i[ADDR_W-1:ISA_W] == '0 && addr_i[BLK_W-1:BLK_W-2] != 2'b00) |-> !hit_o);
  assert_io_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ({base_hi_i, base_i} <= {limit_hi_i, limit_i}));
endmodule

// File: rtl/mem_window_match.sv
module mem_window_match #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FIELD_W-1:0] base_i,
  input  logic [FIELD_W-1:0] limit_i,
  output logic               hit_o
);
  localparam int LOW_W = ADDR_W - FIELD_W;
  logic [ADDR_W-1:0] lo_addr, hi_addr;

  assign lo_addr = {base_i,  {LOW_W{1'b0}}};
  assign hi_addr = {limit_i, {LOW_W{1'b1}}};
  assign hit_o   = (addr_i >= lo_addr) && (addr_i <= hi_addr);

  assert_mem_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (base_i <= limit_i));
  assert_mem_field_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i[ADDR_W-1:LOW_W] >= base_i && addr_i[ADDR_W-1:LOW_W] <= limit_i));
endmodule

// File: rtl/legacy_port_decode.sv
module legacy_port_decode
  import fwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_PORTS = 4,
  parameter int SPAN_W    = 3,
  parameter int SPACE_W   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  output logic                 hit_o
);
  logic [NUM_PORTS-1:0] port_hit;
  logic                 low_space;

  assign low_space = (addr_i[ADDR_W-1:SPACE_W] == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [15:0] PBASE = legacy_port_base(p);
    assign port_hit[p] = port_en_i[p] && low_space &&
                         (addr_i[SPACE_W-1:SPAN_W] == PBASE[SPACE_W-1:SPAN_W]);
  end

  assign hit_o = |port_hit;

  assert_port_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i[ADDR_W-1:SPACE_W] == '0 && port_en_i != '0));
  assert_port_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_hit));
endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import fwd_pkg::*;
#(
  parameter int IO_NIB_W  = 4,
  parameter int IO_GRAN_W = 12,
  parameter int MEM_FLD_W = 12,
  parameter int NUM_PORTS = 4,
  parameter int NUM_MWIN  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_valid_i,
  input  logic [31:0]          addr_i,
  input  logic [3:0]           cmd_i,
  input  logic [IO_NIB_W-1:0]  io_base_i,
  input  logic [IO_NIB_W-1:0]  io_limit_i,
  input  logic [15:0]          io_base_hi_i,
  input  logic [15:0]          io_limit_hi_i,
  input  logic [MEM_FLD_W-1:0] mem_base_i,
  input  logic [MEM_FLD_W-1:0] mem_limit_i,
  input  logic [MEM_FLD_W-1:0] pf_base_i,
  input  logic [MEM_FLD_W-1:0] pf_limit_i,
  input  logic                 isa_en_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  output logic                 fwd_valid_o,
  output logic                 fwd_o
);
  localparam int IO_HI_W = ADDR_W - IO_GRAN_W - IO_NIB_W;

  logic io_win_hit, port_hit;
  logic [NUM_MWIN-1:0] mwin_hit;
  logic [NUM_MWIN-1:0][MEM_FLD_W-1:0] mwin_base, mwin_limit;
  space_e space;
  logic decide;

  assign mwin_base  = {pf_base_i,  mem_base_i};
  assign mwin_limit = {pf_limit_i, mem_limit_i};

  io_window_match #(
    .ADDR_W(ADDR_W), .NIB_W(IO_NIB_W), .GRAN_W(IO_GRAN_W)
  ) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .base_i     (io_base_i),
    .limit_i    (io_limit_i),
    .base_hi_i  (io_base_hi_i[IO_HI_W-1:0]),
    .limit_hi_i (io_limit_hi_i[IO_HI_W-1:0]),
    .isa_en_i   (isa_en_i),
    .hit_o      (io_win_hit)
  );

  for (genvar w = 0; w < NUM_MWIN; w++) begin : g_mwin
    mem_window_match #(.ADDR_W(ADDR_W), .FIELD_W(MEM_FLD_W)) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (addr_i),
      .base_i  (mwin_base[w]),
      .limit_i (mwin_limit[w]),
      .hit_o   (mwin_hit[w])
    );
  end

  legacy_port_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .port_en_i (port_en_i),
    .hit_o     (port_hit)
  );

  assign space = cmd_space(cmd_i);

  always_comb begin
    case (space)
      SPACE_IO:  decide = io_win_hit || port_hit;
      SPACE_MEM: decide = |mwin_hit;
      default:   decide = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_o       <= 1'b0;
    end else begin
      fwd_valid_o <= addr_valid_i;
      fwd_o       <= addr_valid_i && decide;
    end
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i |=> fwd_valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> (!fwd_valid_o && !fwd_o));
  assert_cmd_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && cmd_space(cmd_i) == SPACE_NONE) |=> !fwd_o);
  assert_io_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && cmd_space(cmd_i) == SPACE_IO && !io_win_hit && !port_hit) |=> !fwd_o);
  assert_mem_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && cmd_space(cmd_i) == SPACE_MEM && mwin_hit == '0) |=> !fwd_o);
endmodule

// File: tb/sim_bridge_fwd_decoder.sv
`timescale 1ns/1ps
module sim_bridge_fwd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [3:0]  cmd_i = '0;
  logic [3:0]  io_base_i = 4'hF, io_limit_i = 4'h0;
  logic [15:0] io_base_hi_i = '0, io_limit_hi_i = '0;
  logic [11:0] mem_base_i = 12'hFFF, mem_limit_i = 12'h000;
  logic [11:0] pf_base_i = 12'hFFF, pf_limit_i = 12'h000;
  logic        isa_en_i = 1'b0;
  logic [3:0]  port_en_i = '0;
  logic        fwd_valid_o, fwd_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  bridge_fwd_decoder u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one address phase; result sampled at the next falling edge
  task automatic probe(input string req, input logic [31:0] a, input logic [3:0] c, input logic exp);
    @(negedge clk_i);
    addr_valid_i = 1'b1; addr_i = a; cmd_i = c;
    @(negedge clk_i);
    addr_valid_i = 1'b0;
    chk(req, fwd_valid_o, 1'b1, $sformatf("valid addr=%h", a));
    chk(req, fwd_o, exp, $sformatf("fwd addr=%h cmd=%h", a, c));
  endtask

  task automatic t_reset_R1();
    #1;
    chk("R1", fwd_valid_o, 1'b0, "valid in reset");
    chk("R1", fwd_o, 1'b0, "fwd in reset");
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", fwd_valid_o, 1'b0, "valid after reset");
    chk("R1", fwd_o, 1'b0, "fwd after reset");
  endtask

  task automatic t_latency_R2();
    io_base_i = 4'h2; io_limit_i = 4'h5;
    @(negedge clk_i);
    addr_valid_i = 1'b1; addr_i = 32'h3000; cmd_i = 4'h2;
    @(negedge clk_i);
    chk("R2", fwd_o, 1'b1, "first of pair");
    addr_i = 32'h7000;
    @(negedge clk_i);
    addr_valid_i = 1'b0;
    chk("R2", fwd_valid_o, 1'b1, "second valid");
    chk("R2", fwd_o, 1'b0, "second of pair");
    addr_i = 32'h3000;
    @(negedge clk_i);
    chk("R2", fwd_valid_o, 1'b0, "idle valid");
    chk("R2", fwd_o, 1'b0, "idle fwd");
  endtask

  task automatic t_io_R3();
    io_base_i = 4'h2; io_limit_i = 4'h5; io_base_hi_i = 0; io_limit_hi_i = 0;
    probe("R3", 32'h0000_2000, 4'h2, 1'b1);
    probe("R3", 32'h0000_1FFF, 4'h2, 1'b0);
    probe("R3", 32'h0000_5FFF, 4'h3, 1'b1);
    probe("R3", 32'h0000_6000, 4'h3, 1'b0);
    probe("R3", 32'h0001_3000, 4'h2, 1'b0);
    io_base_hi_i = 16'h0001; io_limit_hi_i = 16'h0001;
    probe("R3", 32'h0001_3000, 4'h2, 1'b1);
    probe("R3", 32'h0000_3000, 4'h2, 1'b0);
    probe("R3", 32'h0001_5FFF, 4'h3, 1'b1);
    io_base_hi_i = 0; io_limit_hi_i = 0;
  endtask

  task automatic t_mem_R4();
    mem_base_i = 12'h100; mem_limit_i = 12'h1FF;
    probe("R4", 32'h0FFF_FFFF, 4'h6, 1'b0);
    probe("R4", 32'h1000_0000, 4'h6, 1'b1);
    probe("R4", 32'h1FFF_FFFF, 4'h7, 1'b1);
    probe("R4", 32'h2000_0000, 4'h7, 1'b0);
    probe("R4", 32'h1800_0000, 4'hC, 1'b1);
    probe("R4", 32'h1800_0000, 4'hF, 1'b1);
  endtask

  task automatic t_pf_R5();
    pf_base_i = 12'h800; pf_limit_i = 12'h80F;
    probe("R5", 32'h80FF_FFFF, 4'hE, 1'b1);
    probe("R5", 32'h8000_0000, 4'h6, 1'b1);
    probe("R5", 32'h8100_0000, 4'hE, 1'b0);
    probe("R5", 32'h7FFF_FFFF, 4'h6, 1'b0);
    probe("R5", 32'h1000_0000, 4'hE, 1'b1);
  endtask

  task automatic t_inverted_R6();
    mem_base_i = 12'h300; mem_limit_i = 12'h2FF;
    pf_base_i = 12'h301; pf_limit_i = 12'h300;
    probe("R6", 32'h2FF0_0000, 4'h6, 1'b0);
    probe("R6", 32'h3000_0000, 4'h6, 1'b0);
    probe("R6", 32'h3010_0000, 4'h7, 1'b0);
    io_base_i = 4'h5; io_limit_i = 4'h2;
    probe("R6", 32'h0000_3000, 4'h2, 1'b0);
    probe("R6", 32'h0000_5000, 4'h2, 1'b0);
  endtask

  task automatic t_isa_R7();
    io_base_i = 4'h0; io_limit_i = 4'hF; isa_en_i = 1'b1;
    probe("R7", 32'h0000_1000, 4'h2, 1'b1);
    probe("R7", 32'h0000_10FF, 4'h2, 1'b1);
    probe("R7", 32'h0000_1100, 4'h2, 1'b0);
    probe("R7", 32'h0000_13FF, 4'h3, 1'b0);
    probe("R7", 32'h0000_1400, 4'h3, 1'b1);
    isa_en_i = 1'b0;
    probe("R7", 32'h0000_1100, 4'h2, 1'b1);
    isa_en_i = 1'b1;
    io_base_hi_i = 16'h0001; io_limit_hi_i = 16'h0001;
    probe("R7", 32'h0001_0100, 4'h2, 1'b1);
    probe("R7", 32'h0001_F3FF, 4'h2, 1'b1);
    io_base_hi_i = 0; io_limit_hi_i = 0; isa_en_i = 1'b0;
  endtask

  task automatic t_ports_R8();
    io_base_i = 4'hF; io_limit_i = 4'h0; isa_en_i = 1'b1;
    port_en_i = 4'b0001;
    probe("R8", 32'h0000_03F8, 4'h2, 1'b1);
    probe("R8", 32'h0000_03FF, 4'h3, 1'b1);
    probe("R8", 32'h0000_03F7, 4'h2, 1'b0);
    probe("R8", 32'h0000_0400, 4'h2, 1'b0);
    probe("R8", 32'h0001_03F8, 4'h2, 1'b0);
    probe("R8", 32'h0000_02F8, 4'h2, 1'b0);
    port_en_i = 4'b0010;
    probe("R8", 32'h0000_02FC, 4'h2, 1'b1);
    port_en_i = 4'b0100;
    probe("R8", 32'h0000_037F, 4'h3, 1'b1);
    probe("R8", 32'h0000_03F8, 4'h2, 1'b0);
    port_en_i = 4'b1000;
    probe("R8", 32'h0000_0278, 4'h2, 1'b1);
    probe("R8", 32'h0000_0280, 4'h2, 1'b0);
    port_en_i = 4'b0001;
    probe("R9", 32'h0000_03F8, 4'h6, 1'b0);
    port_en_i = 4'b0000; isa_en_i = 1'b0;
  endtask

  task automatic t_cmd_R9();
    io_base_i = 4'h2; io_limit_i = 4'h5;
    mem_base_i = 12'h100; mem_limit_i = 12'h1FF;
    probe("R9", 32'h0000_3000, 4'hA, 1'b0);
    probe("R9", 32'h0000_3000, 4'h0, 1'b0);
    probe("R9", 32'h0000_3000, 4'h6, 1'b0);
    probe("R9", 32'h1000_0000, 4'h2, 1'b0);
    probe("R9", 32'h1000_0000, 4'hB, 1'b0);
    probe("R9", 32'h1000_0000, 4'h1, 1'b0);
  endtask

  initial begin
    t_reset_R1();
    t_latency_R2();
    t_io_R3();
    t_mem_R4();
    t_pf_R5();
    t_inverted_R6();
    t_isa_R7();
    t_ports_R8();
    t_cmd_R9();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule